// File: doc/BRIEF.md
# Timer and Watchdog with Shared Prescaler

This block holds an 8-bit timer/counter and a watchdog counter that share one programmable prescaler. The timer advances on instruction-cycle ticks or on edges of an external clock pin, and the active edge is selectable. The instruction-cycle tick is made inside the block from the core clock, divided by 1, 2, 4 or 8. An option register holds three settings: the timer source, the edge polarity, and which path owns the prescaler. Its 3-bit ratio field picks a division of 2, 4, 8, 16, 32, 64, 128 or 256. Timer wrap-around raises an interrupt flag. The watchdog emits a one-clock time-out pulse each time its counter rolls over.

A core reaches the timer and the option register through a single write/read port. Writing the timer reloads it and opens a short hold-off, run by a small state machine. The states are ST_RUN (normal counting), ST_SKIP1 and ST_SKIP2 (the first and second suppressed instruction cycles). The transitions are:
- any state goes to ST_SKIP1 on a timer write;
- ST_SKIP1 goes to ST_SKIP2 on an instruction tick;
- ST_SKIP2 goes to ST_RUN on an instruction tick;
- otherwise each state holds.

A watchdog clear strobe and a sleep strobe restart the watchdog.

Top module: `tw_timer_wdt`

## Requirements
- R1: After reset the timer reads 00h, the option register reads 00h, and the interrupt flag and the time-out output are low.
- R2: reg_sel 0 selects the timer and reg_sel 1 selects the option register, for both writes and reads. The option bits are: [5] external source, [4] falling edge, [3] prescaler given to the watchdog, [2:0] ratio. Bits [7:6] always read 0.
- R3: The instruction-cycle tick occurs once every 1, 2, 4 or 8 clocks for cyc_div_sel values 0, 1, 2 and 3.
- R4: With the internal source selected and the prescaler given to the watchdog, the timer advances once per instruction tick.
- R5: With the prescaler given to the timer, the timer advances once per 2^(ratio+1) source events.
- R6: With option bit 5 set, the pin is synchronized through two flops and the timer advances on the pin's rising edge (bit 4 = 0) or falling edge (bit 4 = 1). The increment lands on the third clock edge after the pin changes. The other edge and the instruction ticks are ignored.
- R7: A timer write loads the value and clears the prescaler when the timer owns it. The next two instruction ticks then do not advance the timer.
- R8: A timer step from FFh to 00h sets tmr_flag. The flag stays set until flag_clr. tmr_irq is tmr_flag AND tmr_ie AND glb_ie.
- R9: The watchdog counts instruction ticks, or prescaler outputs when it owns the prescaler. wdt_timeout pulses high for one clock after the event that finds the counter at all ones, and the counter then wraps to zero.
- R10: wdt_clr zeroes the watchdog counter, and also the prescaler when the watchdog owns it.
- R11: sleep_req zeroes both the watchdog counter and the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_div_sel | input | 2 | Instruction-cycle divide: 0=/1, 1=/2, 2=/4, 3=/8 |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = timer, 1 = option register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ext_clk_pin | input | 1 | External timer clock pin |
| tmr_ie | input | 1 | Timer interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| flag_clr | input | 1 | Clears the overflow flag |
| wdt_clr | input | 1 | Watchdog clear strobe |
| sleep_req | input | 1 | Sleep strobe |
| tmr_flag | output | 1 | Timer overflow flag |
| tmr_irq | output | 1 | Gated interrupt request |
| wdt_timeout | output | 1 | One-clock watchdog time-out pulse |

## Verification
The counting path is driven over fixed windows whose length is a multiple of the expected period. The windows cover every cycle divide with the prescaler on the watchdog side, and several ratios and one divided clock with the prescaler on the timer side. An exact increment count therefore separates a wrong divide, a wrong ratio and a wrong prescaler assignment, whatever the phase.

Directed cases hold the pin at one level after a single transition, which separates rising-edge counting from falling-edge counting and from accidental internal counting. Timer writes are checked cycle by cycle to separate a two-tick hold-off from a missing prescaler clear. Watchdog time-outs are timed from a clear or a sleep strobe, which exposes off-by-one roll-over and prescaler-reset faults.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SKIP1 = 2'd1,
        ST_SKIP2 = 2'd2
    } hold_st_t;

    typedef struct packed {
        logic [1:0] spare;
        logic       src_ext;
        logic       edge_fall;
        logic       pre_wdt;
        logic [2:0] ratio;
    } opt_t;
endpackage

// File: rtl/tw_cycgen.sv
module tw_cycgen #(
    parameter int DIV_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] div_sel,
    output logic       tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask = DIV_W'((1 << div_sel) - 1);
        tick = ((cnt_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // R3
    tick_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_sel != 2'd0) |=> (!tick || div_sel == 2'd0));
endmodule

// File: rtl/tw_pinedge.sv
module tw_pinedge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic evt
);
    logic [SYNC_STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[0] <= 1'b0;
        else        sh_q[0] <= pin;
    end

    for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q[i] <= 1'b0;
            else        sh_q[i] <= sh_q[i-1];
        end
    end

    logic rise, fall;
    always_comb begin
        rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
        fall = ~sh_q[SYNC_STAGES-1] & sh_q[SYNC_STAGES];
        evt  = fall_sel ? fall : rise;
    end
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
    parameter int PW    = 8,
    localparam int SEL_W = $clog2(PW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_evt,
    input  logic             clr,
    input  logic [SEL_W-1:0] ratio,
    output logic             out_evt
);
    logic [PW-1:0] cnt_q;
    logic [PW-1:0] mask;

    always_comb begin
        mask    = PW'((2 << ratio) - 1);
        out_evt = in_evt && ((cnt_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (in_evt) cnt_q <= cnt_q + 1'b1;
    end

    // R5
    presc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_evt && !clr) |=> ((cnt_q & $past(mask)) == '0));
endmodule

// File: rtl/tw_timer_wdt.sv
module tw_timer_wdt
    import tw_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int WDT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cyc_div_sel,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             ext_clk_pin,
    input  logic             tmr_ie,
    input  logic             glb_ie,
    input  logic             flag_clr,
    input  logic             wdt_clr,
    input  logic             sleep_req,
    output logic             tmr_flag,
    output logic             tmr_irq,
    output logic             wdt_timeout
);
    hold_st_t         st_q, st_d;
    opt_t             opt_q;
    logic [REG_W-1:0] tmr_q;
    logic [WDT_W-1:0] wdt_q;
    logic             flag_q, to_q;
    logic             cyc_tick, ext_evt, pre_out;
    logic             tmr_wr, opt_wr, running, src_evt;
    logic             pre_in, pre_clr, tmr_step, wdt_evt, wdt_rst;

    tw_cycgen #(.DIV_W(3)) u_cyc (
        .clk(clk), .rst_n(rst_n), .div_sel(cyc_div_sel), .tick(cyc_tick));

    tw_pinedge #(.SYNC_STAGES(2)) u_pin (
        .clk(clk), .rst_n(rst_n), .pin(ext_clk_pin),
        .fall_sel(opt_q.edge_fall), .evt(ext_evt));

    tw_prescaler #(.PW(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .in_evt(pre_in), .clr(pre_clr),
        .ratio(opt_q.ratio), .out_evt(pre_out));

    always_comb begin
        tmr_wr   = reg_wr & ~reg_sel;
        opt_wr   = reg_wr & reg_sel;
        src_evt  = opt_q.src_ext ? ext_evt : cyc_tick;
        pre_in   = opt_q.pre_wdt ? cyc_tick : (src_evt & running);
        pre_clr  = sleep_req | (wdt_clr & opt_q.pre_wdt) | (tmr_wr & ~opt_q.pre_wdt);
        tmr_step = opt_q.pre_wdt ? (src_evt & running) : pre_out;
        wdt_evt  = opt_q.pre_wdt ? pre_out : cyc_tick;
        wdt_rst  = sleep_req | wdt_clr;
    end

    // hold-off state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:   st_d = tmr_wr ? ST_SKIP1 : ST_RUN;
            ST_SKIP1: st_d = tmr_wr ? ST_SKIP1 : (cyc_tick ? ST_SKIP2 : ST_SKIP1);
            ST_SKIP2: st_d = tmr_wr ? ST_SKIP1 : (cyc_tick ? ST_RUN : ST_SKIP2);
            default:  st_d = ST_RUN;
        endcase
    end

    // state-driven outputs
    always_comb begin
        running     = (st_q == ST_RUN);
        reg_rdata   = reg_sel ? REG_W'(opt_q) : tmr_q;
        tmr_flag    = flag_q;
        tmr_irq     = flag_q & tmr_ie & glb_ie;
        wdt_timeout = to_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opt_q  <= '0;
            tmr_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (opt_wr)        opt_q <= opt_t'({2'b00, reg_wdata[5:0]});
            if (tmr_wr)        tmr_q <= reg_wdata;
            else if (tmr_step) tmr_q <= tmr_q + 1'b1;
            if (tmr_step && !tmr_wr && tmr_q == '1) flag_q <= 1'b1;
            else if (flag_clr)                      flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdt_q <= '0;
            to_q  <= 1'b0;
        end else begin
            to_q <= wdt_evt && !wdt_rst && (wdt_q == '1);
            if (wdt_rst)      wdt_q <= '0;
            else if (wdt_evt) wdt_q <= wdt_q + 1'b1;
        end
    end

    // R7
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_RUN && !tmr_wr) |=> (tmr_q == $past(tmr_q)));

    // R8
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> (tmr_q == '0 && $past(tmr_q) == '1));

    // R9
    wdt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |=> !wdt_timeout);

    // R11
    sleep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> (wdt_q == '0 && !wdt_timeout));
endmodule

// File: tb/tb_tw_timer_wdt.sv
module tb_tw_timer_wdt;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cyc_div_sel = 2'd0;
    logic       reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ext_clk_pin = 1'b0;
    logic       tmr_ie = 1'b0, glb_ie = 1'b0, flag_clr = 1'b0;
    logic       wdt_clr = 1'b0, sleep_req = 1'b0;
    logic       tmr_flag, tmr_irq, wdt_timeout;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    tw_timer_wdt dut (
        .clk(clk), .rst_n(rst_n), .cyc_div_sel(cyc_div_sel),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ext_clk_pin(ext_clk_pin),
        .tmr_ie(tmr_ie), .glb_ie(glb_ie), .flag_clr(flag_clr),
        .wdt_clr(wdt_clr), .sleep_req(sleep_req),
        .tmr_flag(tmr_flag), .tmr_irq(tmr_irq), .wdt_timeout(wdt_timeout));

    // {div[1:0], option[7:0], window[15:0], expected steps[7:0]}
    localparam logic [33:0] VECS [0:7] = '{
        {2'd0, 8'h08, 16'd50,  8'd50},
        {2'd1, 8'h08, 16'd40,  8'd20},
        {2'd2, 8'h08, 16'd40,  8'd10},
        {2'd3, 8'h08, 16'd48,  8'd6},
        {2'd0, 8'h00, 16'd40,  8'd20},
        {2'd0, 8'h03, 16'd64,  8'd4},
        {2'd0, 8'h07, 16'd512, 8'd2},
        {2'd1, 8'h01, 16'd64,  8'd8}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        reg_wr = 1'b0; reg_sel = 1'b0; ext_clk_pin = 1'b0;
        tmr_ie = 1'b0; glb_ie = 1'b0; flag_clr = 1'b0;
        wdt_clr = 1'b0; sleep_req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic pulse_wdt_clr();
        @(negedge clk); wdt_clr = 1'b1;
        @(posedge clk); @(negedge clk); wdt_clr = 1'b0;
    endtask

    task automatic pulse_sleep();
        @(negedge clk); sleep_req = 1'b1;
        @(posedge clk); @(negedge clk); sleep_req = 1'b0;
    endtask

    task automatic pulse_flag_clr();
        @(negedge clk); flag_clr = 1'b1;
        @(posedge clk); @(negedge clk); flag_clr = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] t0, t1;

        // R1 reset state
        do_reset();
        reg_sel = 1'b0; #1;
        check("R1 timer", reg_rdata, 8'h00);
        reg_sel = 1'b1; #1;
        check("R1 option", reg_rdata, 8'h00);
        reg_sel = 1'b0;
        check("R1 flag", tmr_flag, 1'b0);
        check("R1 timeout", wdt_timeout, 1'b0);

        // R2 option readback, spare bits read 0
        wr_reg(1'b1, 8'hFF);
        reg_sel = 1'b1; #1;
        check("R2 option readback", reg_rdata, 8'h3F);
        reg_sel = 1'b0;

        // table: R3 R4 (prescaler on watchdog) and R5 (prescaler on timer)
        for (int i = 0; i < 8; i++) begin
            logic [33:0] v;
            logic [7:0]  d;
            v = VECS[i];
            do_reset();
            cyc_div_sel = v[33:32];
            wr_reg(1'b1, v[31:24]);
            wr_reg(1'b0, 8'h00);
            adv(40);
            t0 = reg_rdata;
            adv(int'(v[23:8]));
            t1 = reg_rdata;
            d = t1 - t0;
            check(v[27] ? "R3 R4 step count" : "R5 step count", d, v[7:0]);
        end
        cyc_div_sel = 2'd0;

        // R7 hold-off, no prescaler
        do_reset();
        wr_reg(1'b1, 8'h08);
        wr_reg(1'b0, 8'h10);
        check("R7 loaded", reg_rdata, 8'h10);
        adv(2);
        check("R7 held two ticks", reg_rdata, 8'h10);
        adv(1);
        check("R7 resumes", reg_rdata, 8'h11);

        // R7 prescaler cleared by timer write (ratio 1:2)
        do_reset();
        wr_reg(1'b1, 8'h00);
        adv(5);
        wr_reg(1'b0, 8'h40);
        adv(3);
        check("R7 prescaler cleared", reg_rdata, 8'h40);
        adv(1);
        check("R7 first step", reg_rdata, 8'h41);

        // R8 overflow flag and irq gating
        do_reset();
        tmr_ie = 1'b1; glb_ie = 1'b1;
        wr_reg(1'b1, 8'h08);
        wr_reg(1'b0, 8'hFE);
        adv(3);
        check("R8 at FF", reg_rdata, 8'hFF);
        check("R8 flag low", tmr_flag, 1'b0);
        adv(1);
        check("R8 wrapped", reg_rdata, 8'h00);
        check("R8 flag set", tmr_flag, 1'b1);
        check("R8 irq", tmr_irq, 1'b1);
        glb_ie = 1'b0; #1;
        check("R8 irq global off", tmr_irq, 1'b0);
        glb_ie = 1'b1; tmr_ie = 1'b0; #1;
        check("R8 irq timer off", tmr_irq, 1'b0);
        tmr_ie = 1'b1;
        adv(5);
        check("R8 flag held", tmr_flag, 1'b1);
        pulse_flag_clr();
        check("R8 flag cleared", tmr_flag, 1'b0);

        // R6 external rising edge
        do_reset();
        wr_reg(1'b1, 8'h28);
        wr_reg(1'b0, 8'h00);
        adv(8);
        check("R6 no internal count", reg_rdata, 8'h00);
        ext_clk_pin = 1'b1;
        adv(2);
        check("R6 sync latency", reg_rdata, 8'h00);
        adv(1);
        check("R6 rising counted", reg_rdata, 8'h01);
        ext_clk_pin = 1'b0;
        adv(6);
        check("R6 falling ignored", reg_rdata, 8'h01);

        // R6 external falling edge
        wr_reg(1'b1, 8'h38);
        wr_reg(1'b0, 8'h00);
        adv(8);
        ext_clk_pin = 1'b1;
        adv(6);
        check("R6 rising ignored", reg_rdata, 8'h00);
        ext_clk_pin = 1'b0;
        adv(6);
        check("R6 falling counted", reg_rdata, 8'h01);

        // R9 R10 watchdog on instruction ticks
        do_reset();
        wr_reg(1'b1, 8'h00);
        adv(7);
        pulse_wdt_clr();
        adv(255);
        check("R10 R9 before roll", wdt_timeout, 1'b0);
        adv(1);
        check("R9 timeout pulse", wdt_timeout, 1'b1);
        adv(1);
        check("R9 pulse one clock", wdt_timeout, 1'b0);

        // R9 R10 watchdog through prescaler 1:2
        do_reset();
        wr_reg(1'b1, 8'h08);
        adv(3);
        pulse_wdt_clr();
        adv(511);
        check("R10 prescaled before roll", wdt_timeout, 1'b0);
        adv(1);
        check("R9 prescaled timeout", wdt_timeout, 1'b1);

        // R11 sleep clears watchdog and prescaler
        adv(3);
        pulse_sleep();
        adv(511);
        check("R11 before roll", wdt_timeout, 1'b0);
        adv(1);
        check("R11 timeout after sleep", wdt_timeout, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule